// File: doc/BRIEF.md
# Pipelined synchronous burst SRAM

This block is a synthesizable behavioural model of a word-wide synchronous static RAM with a processor-style burst front end. Every control input is sampled on the rising clock edge. An access begins when one of two address strobes captures an address. After that, plain clock cycles can continue the access: the advance input steps a 2-bit burst counter that supplies the low address bits, or, when the advance input is high, the access repeats at the same address. Writes cover either the whole word (global write) or selected 8-bit lanes (byte write). Read data is registered at the edge that performs the read and is shown during the following cycle.

The pads are not modelled. Write data enters on `din`, and read data leaves on `dout` together with the flag `dout_vld`. There is no ready signal and no back-pressure. A reader must take `dout` in the cycle in which `dout_vld` is high, because the next edge replaces it. `dout` reads as zero whenever `dout_vld` is low. The default memory has 256 words. Setting `ADDR_W` to 15 gives the full 32K-word array.

Top module: `sbsram`

## Requirements
- R1: The chip is selected when `ce1_n`=0, `ce2`=1 and `ce3_n`=0. A strobe that acts while the chip is unselected deselects the device. A deselected device performs no access and keeps `dout_vld` low until a strobe captures an address again. Reset leaves the device deselected.
- R2: If `adsp_n` and `adsc_n` are both low and `ce1_n` is low, only the processor strobe (`adsp_n`) is acted on.
- R3: `adsp_n` has no effect while `ce1_n` is high. In that case the cycle is handled as if `adsp_n` were high: the controller strobe, or burst continuation, decides what happens.
- R4: A captured address loads its two low bits into the burst counter. In a cycle with no acting strobe, `adv_n`=0 increments the counter modulo 4 (linear order 0,1,2,3,0) and leaves the upper bits fixed. `adv_n`=1 repeats the access at the same address.
- R5: `gw_n`=0 writes all four lanes, whatever `bwe_n` and `bw_n` are.
- R6: With `gw_n`=1, a write happens only when `bwe_n`=0. Each lane i whose `bw_n[i]` is 0 then writes `din[8i+7:8i]`. If no lane is enabled, the cycle is a read.
- R7: A read is performed at the edge where its address becomes current. The read data is on `dout` with `dout_vld`=1 after that same edge, for one cycle. A write cycle gives `dout_vld`=0 in the following cycle.
- R8: `oe_n` acts asynchronously. While it is high, `dout_vld`=0 and `dout`=0. When it goes low, pending read data appears without a clock edge.
- R9: The first read after a deselected state (this includes the state after reset) is masked, so `dout_vld` stays 0 for that cycle. The next read is shown normally.
- R10: While `zz`=1 at an edge, no address is captured, no write occurs and `dout_vld` is 0 in the next cycle. Stored contents are kept.
- R11: A capture by the processor strobe is always a read, even when the write controls are active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all control inputs sampled on the rising edge |
| rst_n | input | 1 | Active-low asynchronous reset of the control state |
| addr | input | ADDR_W | Word address |
| ce1_n | input | 1 | Chip enable 1, active low; also gates the processor strobe |
| ce2 | input | 1 | Chip enable 2, active high |
| ce3_n | input | 1 | Chip enable 3, active low |
| adsp_n | input | 1 | Processor address strobe, active low |
| adsc_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| gw_n | input | 1 | Global write, active low |
| bwe_n | input | 1 | Byte write enable, active low |
| bw_n | input | DATA_W/8 | Per-lane byte selects, active low |
| oe_n | input | 1 | Output enable, active low, asynchronous |
| zz | input | 1 | Sleep; high blocks accesses |
| din | input | DATA_W | Write data |
| dout | output | DATA_W | Read data, zero when not valid |
| dout_vld | output | 1 | Read data valid |

## Verification
First, a sweep over every address uses global writes and processor-strobe reads. Its purpose is to separate correct address decoding and one-edge read timing from aliasing or an extra pipeline stage. Next, all sixteen byte-select patterns go to a single word, which separates lane steering from whole-word writes. The cases where a write is blocked (byte write enable off, both strobes low, sleep) show whether a write takes place when it should not. A burst that starts at low bits 2 wraps through 3, 0 and 1, and held-advance cycles follow it. Together these separate modulo-4 wrap from carry into the upper bits. A final sequence covers a deselect followed by a read, the output enable toggled between edges, and the processor strobe asserted with chip enable 1 high. It separates masking, asynchronous gating and strobe gating from one another.

// File: rtl/sbs_pkg.sv
package sbs_pkg;
  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } sbs_op_e;
endpackage

// File: rtl/sbs_addr_ctl.sv
module sbs_addr_ctl
  import sbs_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              ce1_n,
  input  logic              ce2,
  input  logic              ce3_n,
  input  logic              adsp_n,
  input  logic              adsc_n,
  input  logic              adv_n,
  input  logic              gw_n,
  input  logic              bwe_n,
  input  logic [LANES-1:0]  bw_n,
  input  logic              zz,
  output sbs_op_e           op,
  output logic [ADDR_W-1:0] acc_addr,
  output logic [LANES-1:0]  lane_en,
  output logic              active,
  output logic [1:0]        cnt
);
  localparam int HI_W = ADDR_W - 2;

  logic [HI_W-1:0] hi_q, hi_d;
  logic [1:0]      cnt_q, cnt_d;
  logic            act_q, act_d;
  logic            sel, p_go;

  always_comb begin
    sel     = !ce1_n && ce2 && !ce3_n;
    p_go    = !adsp_n && !ce1_n;
    lane_en = !gw_n ? '1 : (!bwe_n ? ~bw_n : '0);
    hi_d    = hi_q;
    cnt_d   = cnt_q;
    act_d   = act_q;
    op      = OP_NONE;
    if (!zz) begin
      if (p_go) begin
        if (sel) begin
          hi_d  = addr[ADDR_W-1:2];
          cnt_d = addr[1:0];
          act_d = 1'b1;
          op    = OP_READ;
        end else begin
          act_d = 1'b0;
        end
      end else if (!adsc_n) begin
        if (sel) begin
          hi_d  = addr[ADDR_W-1:2];
          cnt_d = addr[1:0];
          act_d = 1'b1;
          op    = (|lane_en) ? OP_WRITE : OP_READ;
        end else begin
          act_d = 1'b0;
        end
      end else if (act_q) begin
        if (!adv_n) cnt_d = cnt_q + 2'd1;
        op = (|lane_en) ? OP_WRITE : OP_READ;
      end
    end
    acc_addr = {hi_d, cnt_d};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q  <= '0;
      cnt_q <= '0;
      act_q <= 1'b0;
    end else begin
      hi_q  <= hi_d;
      cnt_q <= cnt_d;
      act_q <= act_d;
    end
  end

  assign active = act_q;
  assign cnt    = cnt_q;
endmodule

// File: rtl/sbs_store.sv
module sbs_store
  import sbs_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic                clk,
  input  sbs_op_e             op,
  input  logic [ADDR_W-1:0]   acc_addr,
  input  logic [DATA_W/8-1:0] lane_en,
  input  logic [DATA_W-1:0]   din,
  output logic [DATA_W-1:0]   rd_data
);
  localparam int LANES = DATA_W / 8;
  localparam int DEPTH = 1 << ADDR_W;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [7:0] mem [DEPTH];
    always_ff @(posedge clk) begin
      if (op == OP_WRITE && lane_en[g])
        mem[acc_addr] <= din[8*g +: 8];
      if (op == OP_READ)
        rd_data[8*g +: 8] <= mem[acc_addr];
    end
  end
endmodule

// File: rtl/sbs_out.sv
module sbs_out
  import sbs_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  sbs_op_e           op,
  input  logic              was_active,
  input  logic              oe_n,
  input  logic [DATA_W-1:0] rd_data,
  output logic [DATA_W-1:0] dout,
  output logic              dout_vld
);
  logic vld_q, mask_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      mask_q <= 1'b0;
    end else begin
      vld_q  <= (op == OP_READ);
      mask_q <= (op == OP_READ) && !was_active;
    end
  end

  assign dout_vld = vld_q && !mask_q && !oe_n;
  assign dout     = dout_vld ? rd_data : '0;
endmodule

// File: rtl/sbsram.sv
module sbsram
  import sbs_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   addr,
  input  logic                ce1_n,
  input  logic                ce2,
  input  logic                ce3_n,
  input  logic                adsp_n,
  input  logic                adsc_n,
  input  logic                adv_n,
  input  logic                gw_n,
  input  logic                bwe_n,
  input  logic [DATA_W/8-1:0] bw_n,
  input  logic                oe_n,
  input  logic                zz,
  input  logic [DATA_W-1:0]   din,
  output logic [DATA_W-1:0]   dout,
  output logic                dout_vld
);
  localparam int LANES = DATA_W / 8;

  sbs_op_e           op;
  logic [ADDR_W-1:0] acc_addr;
  logic [LANES-1:0]  lane_en;
  logic              active;
  logic [1:0]        cnt;
  logic [DATA_W-1:0] rd_data;

  sbs_addr_ctl #(.ADDR_W(ADDR_W), .LANES(LANES)) u_ctl (
    .clk(clk), .rst_n(rst_n), .addr(addr), .ce1_n(ce1_n), .ce2(ce2),
    .ce3_n(ce3_n), .adsp_n(adsp_n), .adsc_n(adsc_n), .adv_n(adv_n),
    .gw_n(gw_n), .bwe_n(bwe_n), .bw_n(bw_n), .zz(zz), .op(op),
    .acc_addr(acc_addr), .lane_en(lane_en), .active(active), .cnt(cnt)
  );

  sbs_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
    .clk(clk), .op(op), .acc_addr(acc_addr), .lane_en(lane_en),
    .din(din), .rd_data(rd_data)
  );

  sbs_out #(.DATA_W(DATA_W)) u_out (
    .clk(clk), .rst_n(rst_n), .op(op), .was_active(active), .oe_n(oe_n),
    .rd_data(rd_data), .dout(dout), .dout_vld(dout_vld)
  );
endmodule

// File: rtl/sbsram_chk.sv
module sbsram_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              zz,
  input logic              oe_n,
  input logic              adsp_n,
  input logic              adsc_n,
  input logic              adv_n,
  input logic              ce1_n,
  input logic              ce2,
  input logic              ce3_n,
  input logic              active,
  input logic [1:0]        cnt,
  input logic [DATA_W-1:0] dout,
  input logic              dout_vld
);
  logic sel;
  assign sel = !ce1_n && ce2 && !ce3_n;

  p_sleep_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    zz |=> !dout_vld);

  p_oe_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> (!dout_vld && dout == '0));

  p_mask_first_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!zz && !adsp_n && sel && !active) |=> !dout_vld);

  p_burst_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!zz && active && (adsp_n || ce1_n) && adsc_n && !adv_n)
      |=> (cnt == 2'($past(cnt) + 2'd1)));

  p_deselect_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!zz && !adsc_n && (adsp_n || ce1_n) && !sel) |=> (!active && !dout_vld));
endmodule

bind sbsram sbsram_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .zz(zz), .oe_n(oe_n), .adsp_n(adsp_n),
  .adsc_n(adsc_n), .adv_n(adv_n), .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n),
  .active(active), .cnt(cnt), .dout(dout), .dout_vld(dout_vld)
);

// File: tb/sbsram_test.sv
`timescale 1ns/100ps
module sbsram_test;
  localparam int AW = 6;
  localparam int DW = 32;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [AW-1:0] addr;
  logic ce1_n, ce2, ce3_n, adsp_n, adsc_n, adv_n, gw_n, bwe_n, oe_n, zz;
  logic [3:0] bw_n;
  logic [DW-1:0] din, dout;
  logic dout_vld;

  int total = 0;
  int bad = 0;
  bit done = 0;

  logic [DW-1:0] exp_mem [DEPTH];
  logic m_active = 1'b0;
  logic [AW-3:0] m_hi = '0;
  logic [1:0] m_cnt = '0;
  logic e_rdv = 1'b0, e_mask = 1'b0;
  logic [DW-1:0] e_data = '0;

  sbsram #(.ADDR_W(AW), .DATA_W(DW)) uut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .ce1_n(ce1_n), .ce2(ce2),
    .ce3_n(ce3_n), .adsp_n(adsp_n), .adsc_n(adsc_n), .adv_n(adv_n),
    .gw_n(gw_n), .bwe_n(bwe_n), .bw_n(bw_n), .oe_n(oe_n), .zz(zz),
    .din(din), .dout(dout), .dout_vld(dout_vld)
  );

  always #2.5 clk = ~clk;

  task automatic chk(string tag, logic av, logic [DW-1:0] ad, logic ev, logic [DW-1:0] ed);
    total++;
    if (av !== ev || ad !== ed) begin
      bad++;
      $display("FAIL %s: vld=%0b dout=%h expected vld=%0b dout=%h", tag, av, ad, ev, ed);
    end
  endtask

  task automatic defaults();
    addr = '0; ce1_n = 0; ce2 = 1; ce3_n = 0; adsp_n = 1; adsc_n = 1;
    adv_n = 1; gw_n = 1; bwe_n = 1; bw_n = 4'hF; oe_n = 0; zz = 0; din = '0;
  endtask

  // Reference behaviour from the requirements, then one edge and a compare.
  task automatic step(string tag);
    logic sel, acc, wr, prev;
    logic [3:0] ln;
    logic [AW-1:0] a;
    sel = !ce1_n && ce2 && !ce3_n;
    ln = !gw_n ? 4'hF : (!bwe_n ? ~bw_n : 4'h0);
    acc = 0; wr = 0; prev = m_active;
    if (!zz) begin
      if (!adsp_n && !ce1_n) begin
        if (sel) begin m_hi = addr[AW-1:2]; m_cnt = addr[1:0]; m_active = 1; acc = 1; end
        else m_active = 0;
      end else if (!adsc_n) begin
        if (sel) begin m_hi = addr[AW-1:2]; m_cnt = addr[1:0]; m_active = 1; acc = 1; wr = |ln; end
        else m_active = 0;
      end else if (m_active) begin
        if (!adv_n) m_cnt = m_cnt + 2'd1;
        acc = 1; wr = |ln;
      end
    end
    a = {m_hi, m_cnt};
    e_rdv = acc && !wr;
    e_mask = acc && !wr && !prev;
    if (acc && wr) begin
      for (int i = 0; i < 4; i++)
        if (ln[i]) exp_mem[a][8*i +: 8] = din[8*i +: 8];
    end
    if (acc && !wr) e_data = exp_mem[a];
    @(posedge clk); #1;
    chk(tag, dout_vld, dout, e_rdv && !e_mask && !oe_n,
        (e_rdv && !e_mask && !oe_n) ? e_data : '0);
  endtask

  function automatic logic [DW-1:0] pat(int a);
    logic [7:0] b;
    b = 8'(a);
    return {b ^ 8'hC3, ~b, b + 8'h35, b};
  endfunction

  task automatic rd_p(int a, string tag);
    defaults(); addr = AW'(a); adsp_n = 0; step(tag);
  endtask

  initial begin
    defaults();
    repeat (3) @(posedge clk);
    #1; rst_n = 1;
    @(posedge clk); #1;
    chk("R7", dout_vld, dout, 1'b0, '0);

    // full sweep: global write every word, then read back
    for (int a = 0; a < DEPTH; a++) begin
      defaults(); addr = AW'(a); adsc_n = 0; gw_n = 0; bw_n = 4'h0; din = pat(a);
      step("R5");
    end
    for (int a = 0; a < DEPTH; a++) rd_p(a, "R7");

    // every byte-select pattern on one word
    for (int p = 0; p < 16; p++) begin
      defaults(); addr = 6'd10; adsc_n = 0; bwe_n = 0; bw_n = 4'(p);
      din = 32'hA5A5A5A5 ^ (32'h11111111 * p);
      step("R6");
      rd_p(10, "R6");
    end
    defaults(); addr = 6'd11; adsc_n = 0; bw_n = 4'h0; din = 32'hFFFFFFFF; step("R6");
    rd_p(11, "R6");
    defaults(); addr = 6'd12; adsc_n = 0; gw_n = 0; bwe_n = 1; bw_n = 4'hF;
    din = 32'h12345678; step("R5");
    rd_p(12, "R5");

    // burst starting at low bits 2, wrap, then hold
    rd_p(22, "R4");
    for (int k = 0; k < 4; k++) begin defaults(); adv_n = 0; step("R4"); end
    defaults(); step("R4");
    defaults(); step("R4");

    // processor strobe with ce1_n high is ignored: burst continues
    defaults(); ce1_n = 1; adsp_n = 0; adv_n = 0; addr = 6'd40; step("R3");
    defaults(); ce1_n = 1; adsp_n = 0; adsc_n = 0; ce2 = 1; addr = 6'd41; step("R3");

    // both strobes with write controls: processor strobe wins, read only
    defaults(); addr = 6'd30; adsp_n = 0; adsc_n = 0; gw_n = 0; din = 32'hDEADBEEF; step("R2");
    rd_p(30, "R11");

    // deselect, idle, masked first read, then normal
    defaults(); adsc_n = 0; ce2 = 0; step("R1");
    defaults(); step("R1");
    rd_p(7, "R9");
    defaults(); step("R9");

    // output enable asynchronous gating
    defaults(); addr = 6'd8; adsp_n = 0; oe_n = 1; step("R8");
    oe_n = 0; #0.5;
    chk("R8", dout_vld, dout, 1'b1, exp_mem[8]);
    oe_n = 1; #0.5;
    chk("R8", dout_vld, dout, 1'b0, '0);

    // sleep blocks a write
    defaults(); zz = 1; addr = 6'd9; adsc_n = 0; gw_n = 0; din = 32'h0BADF00D; step("R10");
    defaults(); zz = 1; adv_n = 0; step("R10");
    rd_p(9, "R10");
    defaults(); adv_n = 0; step("R10");

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: vld=%0b dout=%h expected run to end", dout_vld, dout);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule